// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This unit sits between instruction fetch and the ALU of an accumulator CPU with 16-bit index, stack and direct-page registers and a 24-bit address space. When it is started with the opcode of an ALU instruction, it reads the mode code in the opcode's low five bits. It then pulls the operand bytes that follow the opcode, starting at the program counter. For indirect modes it also reads a 16-bit or 24-bit pointer. It reports the final effective address and the program counter that follows the operand bytes, and it pulses a done strobe.

All memory traffic goes through one byte-wide read port with a request/valid handshake, so the memory may take any number of cycles to answer. The register values and the PC are captured when the start pulse is accepted. The ALU operation, stores, bank registers and extra cycles for page crossings are not part of this unit.

Top module: `ea_seq`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and illegal_o are all 0.
- R2: The mode comes from opcode bits [4:0] only; bits [7:5] have no effect. The legal codes are 01, 03, 05, 07, 09, 0D, 0F, 11, 12, 13, 15, 17, 19, 1D and 1F (hex). Every other code is illegal.
- R3: Operand bytes are read at PC, PC+1 and PC+2 and assembled little-endian. pc_o is pc_i plus the operand length, taken modulo 2^24. The length is 1 for the direct-page and stack modes, 2 for the absolute modes and 3 for the long modes. Code 09 (immediate) reads nothing, gives ea_o = pc_i and gives pc_o = pc_i+1.
- R4: Code 05 gives D+b0, where b0 is the first operand byte. Code 15 gives D + ((b0+X) mod 256). All sums are 24 bits wide and are not truncated to 16 bits.
- R5: Indirect modes read a pointer, low byte first, from consecutive addresses. Code 01 reads a 16-bit pointer at D+((b0+X) mod 256). Code 12 reads a 16-bit pointer at D+b0. Code 11 reads the same pointer as code 12 and then adds Y. Code 07 reads a 24-bit pointer at D+b0. Code 17 reads the same pointer as code 07 and then adds Y. Every sum is taken modulo 2^24.
- R6: Code 03 gives SP+b0. Code 13 reads a 16-bit pointer at SP+b0 and then adds Y.
- R7: Code 0D gives the 16-bit operand, zero-extended. Code 19 adds Y to that value and code 1D adds X. Code 0F gives the 24-bit operand and code 1F adds X to it. All sums are taken modulo 2^24.
- R8: mem_req_o and mem_addr_o stay unchanged until mem_valid_i arrives. Each valid delivers exactly one byte. A valid that arrives while no request is pending has no effect. An instruction makes exactly as many reads as its operand bytes plus its pointer bytes.
- R9: done_o is a one-cycle pulse. When done_o is high, busy_o is low. ea_o, pc_o and illegal_o hold their values until the next start.
- R10: start_i is ignored while busy_o is high.
- R11: After an illegal code, done_o pulses on the cycle after start with illegal_o=1, ea_o=0 and pc_o=pc_i. No memory read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin decoding opcode_i |
| opcode_i | input | 8 | Instruction opcode |
| pc_i | input | 24 | Address of the first operand byte |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| sp_i | input | 16 | Stack pointer |
| dp_i | input | 16 | Direct-page base register |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 24 | Byte read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | Last opcode had no legal mode |
| ea_o | output | 24 | Effective address |
| pc_o | output | 24 | PC after the operand bytes |

## Verification
The assertions assume that mem_valid_i is only ever a single-cycle pulse answering a pending request. They also assume that pc_i is stable on the cycle in which an illegal opcode is started. The bench's memory model raises valid for exactly one cycle per request, after a latency of zero to two cycles. It drives pc_i only together with start_i. The one deliberate stray valid is injected while the unit is idle, and the bench confirms that it has no effect.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        M_XIND, M_STK, M_DIR, M_DIR_LIND, M_IMM, M_ABS, M_LONG,
        M_IND_Y, M_IND, M_STK_IND_Y, M_DIR_X, M_LIND_Y,
        M_ABS_Y, M_ABS_X, M_LONG_X, M_BAD
    } amode_e;

    // n_opr: operand bytes fetched, n_ptr: pointer bytes fetched,
    // pc_adv: amount the program counter moves past the operand field
    typedef struct packed {
        amode_e     mode;
        logic [1:0] n_opr;
        logic [1:0] n_ptr;
        logic [1:0] pc_adv;
        logic       legal;
    } minfo_t;

    function automatic minfo_t decode_mode(input logic [4:0] code);
        minfo_t m;
        case (code)
            5'h01: m = '{M_XIND,      2'd1, 2'd2, 2'd1, 1'b1};
            5'h03: m = '{M_STK,       2'd1, 2'd0, 2'd1, 1'b1};
            5'h05: m = '{M_DIR,       2'd1, 2'd0, 2'd1, 1'b1};
            5'h07: m = '{M_DIR_LIND,  2'd1, 2'd3, 2'd1, 1'b1};
            5'h09: m = '{M_IMM,       2'd0, 2'd0, 2'd1, 1'b1};
            5'h0D: m = '{M_ABS,       2'd2, 2'd0, 2'd2, 1'b1};
            5'h0F: m = '{M_LONG,      2'd3, 2'd0, 2'd3, 1'b1};
            5'h11: m = '{M_IND_Y,     2'd1, 2'd2, 2'd1, 1'b1};
            5'h12: m = '{M_IND,       2'd1, 2'd2, 2'd1, 1'b1};
            5'h13: m = '{M_STK_IND_Y, 2'd1, 2'd2, 2'd1, 1'b1};
            5'h15: m = '{M_DIR_X,     2'd1, 2'd0, 2'd1, 1'b1};
            5'h17: m = '{M_LIND_Y,    2'd1, 2'd3, 2'd1, 1'b1};
            5'h19: m = '{M_ABS_Y,     2'd2, 2'd0, 2'd2, 1'b1};
            5'h1D: m = '{M_ABS_X,     2'd2, 2'd0, 2'd2, 1'b1};
            5'h1F: m = '{M_LONG_X,    2'd3, 2'd0, 2'd3, 1'b1};
            default: m = '{M_BAD,     2'd0, 2'd0, 2'd0, 1'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
(
    input  logic [7:0] opcode,
    output minfo_t     info
);
    // The operation field in the upper bits does not influence addressing
    logic unused_op_hi;
    assign unused_op_hi = ^opcode[7:5];

    assign info = decode_mode(opcode[4:0]);
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned RW = 16
) (
    input  amode_e        mode,
    input  logic [AW-1:0] opr,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] pc,
    input  logic [RW-1:0] x,
    input  logic [RW-1:0] y,
    input  logic [RW-1:0] sp,
    input  logic [RW-1:0] dp,
    output logic [AW-1:0] ptr_base,
    output logic [AW-1:0] ea
);
    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic [AW-1:0]     b0, w16, xz, yz, base_dir, base_dirx, base_stk;
    logic [BYTE_W-1:0] wrap_off;

    assign b0        = AW'(opr[BYTE_W-1:0]);
    assign w16       = AW'(opr[WORD_W-1:0]);
    assign xz        = AW'(x);
    assign yz        = AW'(y);
    assign wrap_off  = opr[BYTE_W-1:0] + x[BYTE_W-1:0];
    assign base_dir  = AW'(dp) + b0;
    assign base_dirx = AW'(dp) + AW'(wrap_off);
    assign base_stk  = AW'(sp) + b0;

    always_comb begin
        ptr_base = base_dir;
        ea       = '0;
        case (mode)
            M_XIND:      begin ptr_base = base_dirx; ea = ptr; end
            M_STK:       ea = base_stk;
            M_DIR:       ea = base_dir;
            M_DIR_LIND:  ea = ptr;
            M_IMM:       ea = pc;
            M_ABS:       ea = w16;
            M_LONG:      ea = opr;
            M_IND_Y:     ea = ptr + yz;
            M_IND:       ea = ptr;
            M_STK_IND_Y: begin ptr_base = base_stk; ea = ptr + yz; end
            M_DIR_X:     ea = base_dirx;
            M_LIND_Y:    ea = ptr + yz;
            M_ABS_Y:     ea = w16 + yz;
            M_ABS_X:     ea = w16 + xz;
            M_LONG_X:    ea = opr + xz;
            default:     ea = '0;
        endcase
    end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [7:0]    opcode_i,
    input  logic [AW-1:0] pc_i,
    input  logic [RW-1:0] x_i,
    input  logic [RW-1:0] y_i,
    input  logic [RW-1:0] sp_i,
    input  logic [RW-1:0] dp_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_valid_i,
    input  logic [7:0]    mem_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          illegal_o,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] pc_o
);
    typedef enum logic [1:0] {S_IDLE, S_OPR, S_PTR, S_CALC} state_e;

    state_e        st;
    minfo_t        dec, info_q;
    logic [1:0]    idx;
    logic [AW-1:0] opr_q, ptr_q, pc_q, ptr_base, ea_calc;
    logic [RW-1:0] x_q, y_q, sp_q, dp_q;
    logic          done_q, ill_q;
    logic [AW-1:0] ea_q, pco_q;
    logic          last_opr, last_ptr;

    ea_decode u_dec (.opcode(opcode_i), .info(dec));

    ea_addr_calc #(.AW(AW), .RW(RW)) u_calc (
        .mode(info_q.mode), .opr(opr_q), .ptr(ptr_q), .pc(pc_q),
        .x(x_q), .y(y_q), .sp(sp_q), .dp(dp_q),
        .ptr_base(ptr_base), .ea(ea_calc)
    );

    assign last_opr   = (idx == info_q.n_opr - 2'd1);
    assign last_ptr   = (idx == info_q.n_ptr - 2'd1);
    assign mem_req_o  = (st == S_OPR) || (st == S_PTR);
    assign mem_addr_o = ((st == S_PTR) ? ptr_base : pc_q) + AW'(idx);
    assign busy_o     = (st != S_IDLE);
    assign done_o     = done_q;
    assign illegal_o  = ill_q;
    assign ea_o       = ea_q;
    assign pc_o       = pco_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            info_q <= '{M_BAD, 2'd0, 2'd0, 2'd0, 1'b0};
            idx    <= '0;
            opr_q  <= '0;
            ptr_q  <= '0;
            pc_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            sp_q   <= '0;
            dp_q   <= '0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            ea_q   <= '0;
            pco_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: if (start_i) begin
                    info_q <= dec;
                    pc_q   <= pc_i;
                    x_q    <= x_i;
                    y_q    <= y_i;
                    sp_q   <= sp_i;
                    dp_q   <= dp_i;
                    idx    <= '0;
                    opr_q  <= '0;
                    ptr_q  <= '0;
                    ill_q  <= !dec.legal;
                    if (!dec.legal) begin
                        ea_q   <= '0;
                        pco_q  <= pc_i;
                        done_q <= 1'b1;
                    end else begin
                        st <= (dec.n_opr == 2'd0) ? S_CALC : S_OPR;
                    end
                end
                S_OPR: if (mem_valid_i) begin
                    opr_q[BYTE_W*idx +: BYTE_W] <= mem_data_i;
                    if (last_opr) begin
                        idx <= '0;
                        st  <= (info_q.n_ptr != 2'd0) ? S_PTR : S_CALC;
                    end else begin
                        idx <= idx + 2'd1;
                    end
                end
                S_PTR: if (mem_valid_i) begin
                    ptr_q[BYTE_W*idx +: BYTE_W] <= mem_data_i;
                    if (last_ptr) begin
                        idx <= '0;
                        st  <= S_CALC;
                    end else begin
                        idx <= idx + 2'd1;
                    end
                end
                default: begin
                    ea_q   <= ea_calc;
                    pco_q  <= pc_q + AW'(info_q.pc_adv);
                    done_q <= 1'b1;
                    st     <= S_IDLE;
                end
            endcase
        end
    end

    // R8: an outstanding read keeps its request and address until answered
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R9: completion is reported only once the sequence has left the busy states
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !mem_req_o));

    // R10: a busy sequence can only end through a done strobe
    a_r10_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    // R11: an illegal code leaves the PC untouched and reports a zero address
    a_r11_illegal_pc: assert property (@(posedge clk) disable iff (rst)
        (done_o && illegal_o) |-> (pc_o == $past(pc_i) && ea_o == '0));

    // R1: nothing is requested while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o);

endmodule

// File: tb/ea_seq_tb.sv
module ea_seq_tb;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        start_i = 0;
    logic [7:0]  opcode_i = 0;
    logic [23:0] pc_i = 0;
    logic [15:0] x_i = 0, y_i = 0, sp_i = 0, dp_i = 0;
    logic        mem_req_o, mem_valid_i;
    logic [23:0] mem_addr_o;
    logic [7:0]  mem_data_i = 0;
    logic        busy_o, done_o, illegal_o;
    logic [23:0] ea_o, pc_o;

    logic valid_r = 0, stray = 0;
    int   lat = 0, wcnt = 0, rd_cnt = 0, dn_cnt = 0;
    int   checks = 0, fails = 0;

    assign mem_valid_i = valid_r | stray;

    always #(CLK_P/2) clk = ~clk;

    ea_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
        .pc_i(pc_i), .x_i(x_i), .y_i(y_i), .sp_i(sp_i), .dp_i(dp_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o),
        .ea_o(ea_o), .pc_o(pc_o)
    );

    function automatic logic [7:0] memf(input logic [23:0] a);
        return 8'((a[7:0] * 7) + (a[15:8] ^ 8'h5C) + (a[23:16] * 13) + 8'h35);
    endfunction

    // memory model: answers each request after lat cycles with a one-cycle valid
    always @(negedge clk) begin
        if (valid_r) begin
            valid_r <= 0;
            wcnt    <= 0;
        end else if (mem_req_o) begin
            if (wcnt >= lat) begin
                valid_r    <= 1;
                mem_data_i <= memf(mem_addr_o);
                rd_cnt     <= rd_cnt + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
        if (done_o) dn_cnt <= dn_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] rd16(input logic [23:0] a);
        return {8'h00, memf(a + 24'd1), memf(a)};
    endfunction
    function automatic logic [23:0] rd24(input logic [23:0] a);
        return {memf(a + 24'd2), memf(a + 24'd1), memf(a)};
    endfunction

    task automatic model(input logic [7:0] op, input logic [23:0] pc,
                         input logic [15:0] x, y, sp, d,
                         output logic [23:0] ea, output logic [23:0] npc,
                         output bit ill, output int nrd);
        logic [7:0]  b0, b1, b2, wo;
        logic [23:0] dpb, dpxb, srb, w16, w24, xx, yy;
        b0 = memf(pc); b1 = memf(pc + 24'd1); b2 = memf(pc + 24'd2);
        wo = b0 + x[7:0];
        dpb = {8'h00, d} + {16'h0, b0};
        dpxb = {8'h00, d} + {16'h0, wo};
        srb = {8'h00, sp} + {16'h0, b0};
        w16 = {8'h00, b1, b0}; w24 = {b2, b1, b0};
        xx = {8'h00, x}; yy = {8'h00, y};
        ill = 0; ea = 0; npc = pc + 24'd1; nrd = 1;
        case (op[4:0])
            5'h01: begin ea = rd16(dpxb); nrd = 3; end
            5'h03: ea = srb;
            5'h05: ea = dpb;
            5'h07: begin ea = rd24(dpb); nrd = 4; end
            5'h09: begin ea = pc; nrd = 0; end
            5'h0D: begin ea = w16; npc = pc + 24'd2; nrd = 2; end
            5'h0F: begin ea = w24; npc = pc + 24'd3; nrd = 3; end
            5'h11: begin ea = rd16(dpb) + yy; nrd = 3; end
            5'h12: begin ea = rd16(dpb); nrd = 3; end
            5'h13: begin ea = rd16(srb) + yy; nrd = 3; end
            5'h15: ea = dpxb;
            5'h17: begin ea = rd24(dpb) + yy; nrd = 4; end
            5'h19: begin ea = w16 + yy; npc = pc + 24'd2; nrd = 2; end
            5'h1D: begin ea = w16 + xx; npc = pc + 24'd2; nrd = 2; end
            5'h1F: begin ea = w24 + xx; npc = pc + 24'd3; nrd = 3; end
            default: begin ill = 1; npc = pc; nrd = 0; end
        endcase
    endtask

    task automatic run_op(input logic [7:0] op, input logic [23:0] pc,
                          input logic [15:0] x, y, sp, d);
        logic [23:0] e_ea, e_pc;
        bit e_ill;
        int e_rd, rd0, n;
        string tg;
        model(op, pc, x, y, sp, d, e_ea, e_pc, e_ill, e_rd);
        tg = e_ill ? "R11" : (op[4:0] == 5'h09 ? "R3" :
             (op[3:0] == 4'hD || op[3:0] == 4'hF) ? "R7" :
             (op[4:0] == 5'h03 || op[4:0] == 5'h13) ? "R6" :
             (op[4:0] == 5'h05 || op[4:0] == 5'h15) ? "R4" : "R5");
        rd0 = rd_cnt;
        opcode_i = op; pc_i = pc; x_i = x; y_i = y; sp_i = sp; dp_i = d;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        n = 0;
        while (!done_o && n < 300) begin @(negedge clk); n++; end
        chk(done_o == 1, {tg, " done R2"}, {23'h0, done_o}, 24'h1);
        chk(!busy_o, "R9 busy at done", {23'h0, busy_o}, 24'h0);
        chk(illegal_o == e_ill, {tg, " illegal flag R2"}, {23'h0, illegal_o}, {23'h0, e_ill});
        chk(ea_o == e_ea, {tg, " effective address"}, ea_o, e_ea);
        chk(pc_o == e_pc, "R3 next pc", pc_o, e_pc);
        @(negedge clk);
        chk(rd_cnt - rd0 == e_rd, "R8 read count", 24'(rd_cnt - rd0), 24'(e_rd));
        chk(!done_o, "R9 done one cycle", {23'h0, done_o}, 24'h0);
    endtask

    initial begin
        #(CLK_P * 180000);
        fails++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] hold_ea, e_ea, e_pc;
        bit e_ill;
        int e_rd, d0;
        logic [23:0] pcs [4] = '{24'h000200, 24'hFFFFFE, 24'h123456, 24'h7FFFFF};
        logic [15:0] xs  [4] = '{16'h0003, 16'h00F0, 16'hABCD, 16'h0000};
        logic [15:0] ys  [4] = '{16'h0010, 16'hFFFF, 16'h0001, 16'h8000};
        logic [15:0] sps [4] = '{16'h01F0, 16'hFFF8, 16'h0100, 16'h0000};
        logic [15:0] ds  [4] = '{16'h0000, 16'h1234, 16'hFF80, 16'h00FF};

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && !mem_req_o && !illegal_o, "R1 reset outputs",
            {20'h0, busy_o, done_o, mem_req_o, illegal_o}, 24'h0);

        // R8: a stray valid with no request pending has no effect
        stray = 1; @(negedge clk); stray = 0; @(negedge clk);
        chk(!busy_o && !done_o, "R8 stray valid ignored", {22'h0, busy_o, done_o}, 24'h0);

        // R2..R8, R11: sweep every mode code under several register sets and latencies
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 3; l++) begin
                lat = l;
                for (int c = 0; c < 32; c++)
                    run_op({3'((p + l + c) % 8), 5'(c)}, pcs[p], xs[p], ys[p], sps[p], ds[p]);
            end

        // R9: outputs hold after completion
        lat = 1;
        run_op(8'h6F, 24'h00ABCD, 16'h0, 16'h0, 16'h0, 16'h0);
        hold_ea = ea_o;
        repeat (5) @(negedge clk);
        chk(ea_o == hold_ea, "R9 outputs hold", ea_o, hold_ea);

        // R10: a start while busy is ignored
        lat = 2;
        model(8'h71, 24'h004000, 16'h0005, 16'h0022, 16'h01FF, 16'h0300, e_ea, e_pc, e_ill, e_rd);
        d0 = dn_cnt;
        opcode_i = 8'h71; pc_i = 24'h004000; x_i = 16'h0005; y_i = 16'h0022;
        sp_i = 16'h01FF; dp_i = 16'h0300;
        start_i = 1; @(negedge clk); start_i = 0;
        repeat (3) @(negedge clk);
        opcode_i = 8'h02; pc_i = 24'h999999; start_i = 1;
        @(negedge clk); start_i = 0;
        for (int k = 0; k < 60 && !done_o; k++) @(negedge clk);
        chk(ea_o == e_ea, "R10 first op result kept", ea_o, e_ea);
        chk(pc_o == e_pc && !illegal_o, "R10 pc unaffected", pc_o, e_pc);
        repeat (6) @(negedge clk);
        chk(dn_cnt - d0 == 1, "R10 single done", 24'(dn_cnt - d0), 24'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule